// File: doc/BRIEF.md
# Wake-up and Kickstart Power Request Controller

This block holds the power-request and interrupt logic of a battery-backed timekeeping device. It watches three inputs. The first is a one-cycle wake-up alarm event. The second is an active-low kickstart line, which is asynchronous. The third tells whether the main supply is present. The block keeps one sticky flag for wake and one for kickstart. Each flag has its own enable bit in an 8-bit control register. The flags drive two active-low outputs: a power-request line that can float, and an interrupt line.

While the main supply is missing, an enabled flag pulls only the power-request line low. The interrupt joins it once the supply returns. A hold bit in the control register decides what the power-request line does during supply loss: it either goes to high impedance or stays driven. The host writes the control register. The host clears the flags by writing ones to the flag address. The clock-output enable bit in the control register sets itself whenever the main supply comes up.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After synchronous reset with the supply absent, the control register and both flags read 0, `pwr_req_n` and `irq_n` are 1, and `pwr_req_oe` is 0.
- R2: A write with `reg_sel`=0 loads `reg_wdata` into the control register. `ctrl_q` reads it back on the next cycle. Bit 7 is aux battery enable, bit 6 clock-output enable, bit 5 crystal select, bit 4 RAM clear enable, bit 3 power-pin hold, bit 2 RAM-clear interrupt enable, bit 1 wake enable, and bit 0 kickstart enable.
- R3: A one-cycle high on `wake_evt` sets the wake flag, which is `flags_q[1]`, whatever the enables hold.
- R4: A falling edge on `kick_n` sets the kickstart flag, which is `flags_q[0]`, exactly once per low pulse. If the flag is cleared while `kick_n` stays low, it remains clear.
- R5: A write with `reg_sel`=1 clears each flag whose `reg_wdata` bit (1 for wake, 0 for kickstart) is 1. An event that arrives in the same cycle wins over the clear.
- R6: With the supply present and a flag set together with its enable, both `pwr_req_n` and `irq_n` are 0.
- R7: With the supply absent, `irq_n` stays 1 and an enabled set flag drives `pwr_req_n` to 0. `irq_n` falls 3 cycles after `main_pwr` rises.
- R8: A flag whose enable is 0 has no effect on either output.
- R9: `pwr_req_oe` is 1 while the supply is present. While the supply is absent it equals the hold bit, so that bit 3 = 0 means high impedance.
- R10: A rise of `main_pwr` sets control bit 6. `ctrl_q[6]` shows the change 3 cycles after the rise.
- R11: `pwr_req_n` and `irq_n` respond 2 cycles after a `wake_evt` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_pwr | input | 1 | Main supply present (asynchronous) |
| wake_evt | input | 1 | Wake-up alarm event pulse |
| kick_n | input | 1 | Active-low kickstart input (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects flag clear |
| reg_wdata | input | 8 | Write data |
| ctrl_q | output | 8 | Control register contents |
| flags_q | output | 2 | Flags: bit 1 wake, bit 0 kickstart |
| pwr_req_n | output | 1 | Power-request data, active low |
| pwr_req_oe | output | 1 | Power-request output enable |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A wake pulse reaches the flag one cycle later and reaches the outputs two cycles later. A kickstart edge passes two synchronizer stages before the flag sets, so it reaches the outputs four cycles after the edge. A supply change reaches `irq_n`, `pwr_req_oe` and control bit 6 after three cycles. Directed checks sample at those exact cycles, and they also sample one cycle earlier to confirm the output has not yet changed. The random sequence applies an operation, then waits six cycles before it compares every output with the bench model, which is longer than any of these latencies.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  // Control register, MSB first; host software decodes these positions.
  typedef struct packed {
    logic aux_bat_en;
    logic clk32_en;
    logic xtal_sel;
    logic ramclr_en;
    logic hold_drive;
    logic ramclr_irq_en;
    logic wake_en;
    logic kick_en;
  } ctrl_t;

  localparam int unsigned CTRL_W   = $bits(ctrl_t);
  localparam logic        SEL_CTRL = 1'b0;
  localparam logic        SEL_FLAG = 1'b1;
  localparam int unsigned FLAG_W   = 2;
  localparam int unsigned WAKE_BIT = 1;
  localparam int unsigned KICK_BIT = 0;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok,
  input  logic              kick_lvl,
  input  logic              wake_evt,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] reg_wdata,
  output ctrl_t             ctrl,
  output logic [FLAG_W-1:0] flags
);
  logic pwr_prev, kick_prev;
  logic pwr_rise, kick_fall;
  logic ctrl_wr, flag_wr;
  ctrl_t             ctrl_nx;
  logic [FLAG_W-1:0] set_vec, clr_vec, flags_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_prev  <= 1'b0;
      kick_prev <= 1'b1;
    end else begin
      pwr_prev  <= pwr_ok;
      kick_prev <= kick_lvl;
    end
  end

  assign pwr_rise  = pwr_ok & ~pwr_prev;
  assign kick_fall = kick_prev & ~kick_lvl;
  assign ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
  assign flag_wr   = reg_wr && (reg_sel == SEL_FLAG);

  always_comb begin
    ctrl_nx = ctrl;
    if (ctrl_wr) ctrl_nx = ctrl_t'(reg_wdata);
    if (pwr_rise) ctrl_nx.clk32_en = 1'b1;
  end

  always_comb begin
    set_vec           = '0;
    set_vec[WAKE_BIT] = wake_evt;
    set_vec[KICK_BIT] = kick_fall;
    clr_vec           = flag_wr ? reg_wdata[FLAG_W-1:0] : '0;
    flags_nx          = (flags & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      flags <= '0;
    end else begin
      ctrl  <= ctrl_nx;
      flags <= flags_nx;
    end
  end

  // R3
  wake_set_chk: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> flags[WAKE_BIT]);

  // R5
  wake_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && reg_wdata[WAKE_BIT] && !wake_evt) |=> !flags[WAKE_BIT]);

  // R10
  clk32_force_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_rise |=> ctrl.clk32_en);
endmodule

// File: rtl/pwr_outs.sv
module pwr_outs
  import pwr_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok,
  input  logic              hold_drive,
  input  logic              wake_en,
  input  logic              kick_en,
  input  logic [FLAG_W-1:0] flags,
  output logic              pwr_req_n,
  output logic              pwr_req_oe,
  output logic              irq_n
);
  logic req;

  assign req = (flags[WAKE_BIT] & wake_en) | (flags[KICK_BIT] & kick_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_req_n  <= 1'b1;
      pwr_req_oe <= 1'b0;
      irq_n      <= 1'b1;
    end else begin
      pwr_req_n  <= ~req;
      pwr_req_oe <= pwr_ok | hold_drive;
      irq_n      <= ~(req & pwr_ok);
    end
  end

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> irq_n);

  // R9
  oe_on_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_ok |=> pwr_req_oe);

  // R8
  no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!wake_en && !kick_en) |=> (pwr_req_n && irq_n));
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl
  import pwr_wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        main_pwr,
  input  logic        wake_evt,
  input  logic        kick_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  ctrl_q,
  output logic [1:0]  flags_q,
  output logic        pwr_req_n,
  output logic        pwr_req_oe,
  output logic        irq_n
);
  logic              pwr_ok, kick_lvl;
  ctrl_t             ctrl;
  logic [FLAG_W-1:0] flags;

  pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
    .clk(clk), .rst(rst), .d(main_pwr), .q(pwr_ok));

  pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_kick_sync (
    .clk(clk), .rst(rst), .d(kick_n), .q(kick_lvl));

  pwr_regs u_regs (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .kick_lvl(kick_lvl),
    .wake_evt(wake_evt), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl(ctrl), .flags(flags));

  pwr_outs u_outs (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .hold_drive(ctrl.hold_drive),
    .wake_en(ctrl.wake_en), .kick_en(ctrl.kick_en), .flags(flags),
    .pwr_req_n(pwr_req_n), .pwr_req_oe(pwr_req_oe), .irq_n(irq_n));

  assign ctrl_q  = ctrl;
  assign flags_q = flags;
endmodule

// File: tb/pwr_wake_ctl_bench.sv
module pwr_wake_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       main_pwr = 1'b0, wake_evt = 1'b0, kick_n = 1'b1;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctrl_q;
  logic [1:0] flags_q;
  logic       pwr_req_n, pwr_req_oe, irq_n;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_ctrl = '0;
  logic       m_wf = 0, m_kf = 0, m_pwr = 0;

  always #2.5 clk = ~clk;

  pwr_wake_ctl u_pwr_wake_ctl (
    .clk(clk), .rst(rst), .main_pwr(main_pwr), .wake_evt(wake_evt),
    .kick_n(kick_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .flags_q(flags_q),
    .pwr_req_n(pwr_req_n), .pwr_req_oe(pwr_req_oe), .irq_n(irq_n));

  function automatic logic f_req();
    return (m_wf & m_ctrl[1]) | (m_kf & m_ctrl[0]);
  endfunction
  function automatic logic f_pn();  return ~f_req();              endfunction
  function automatic logic f_irq(); return ~(f_req() & m_pwr);    endfunction
  function automatic logic f_oe();  return m_pwr | m_ctrl[3];     endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 ctrl"},  ctrl_q, m_ctrl);
    chk({tag, " R3/R4 flags"}, {6'd0, flags_q}, {6'd0, m_wf, m_kf});
    chk({tag, " R6/R8 pwr_req_n"}, {7'd0, pwr_req_n}, {7'd0, f_pn()});
    chk({tag, " R7 irq_n"}, {7'd0, irq_n}, {7'd0, f_irq()});
    chk({tag, " R9 oe"}, {7'd0, pwr_req_oe}, {7'd0, f_oe()});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 outs", {5'd0, pwr_req_n, irq_n, pwr_req_oe}, 8'b110);

    // R11 wake latency, supply absent, enable on, hold on (R2 layout)
    wr(1'b0, 8'h0A); m_ctrl = 8'h0A;
    step(1);
    chk("R2 readback", ctrl_q, 8'h0A);
    chk("R9 hold drives oe", {7'd0, pwr_req_oe}, 8'd1);
    wake_evt = 1'b1; step(1); wake_evt = 1'b0; m_wf = 1;
    chk("R11 not yet", {7'd0, pwr_req_n}, 8'd1);
    chk("R3 flag set", {6'd0, flags_q}, 8'd2);
    step(1);
    chk("R11 pwr_req_n low", {7'd0, pwr_req_n}, 8'd0);
    chk("R7 irq quiet", {7'd0, irq_n}, 8'd1);
    // R7 / R10 supply return latency
    main_pwr = 1'b1; m_pwr = 1;
    step(2);
    chk("R7 irq not yet", {7'd0, irq_n}, 8'd1);
    step(1);
    chk("R7 irq low", {7'd0, irq_n}, 8'd0);
    chk("R10 clk32 set", {7'd0, ctrl_q[6]}, 8'd1);
    m_ctrl[6] = 1'b1;
    // R5 set wins over clear
    wake_evt = 1'b1; wr(1'b1, 8'h02); wake_evt = 1'b0;
    step(3);
    chk("R5 set wins", {6'd0, flags_q}, 8'd2);
    wr(1'b1, 8'h02); m_wf = 0; step(3);
    check_all("R5 clear");
    // R4 kick held low: cleared flag stays clear
    wr(1'b0, 8'h01); m_ctrl = 8'h01;
    kick_n = 1'b0; step(5); m_kf = 1;
    check_all("R4 kick");
    wr(1'b1, 8'h01); m_kf = 0; step(5);
    check_all("R4 held low");
    kick_n = 1'b1; step(4);
    // R9 float on supply loss with hold 0
    main_pwr = 1'b0; m_pwr = 0; step(5);
    chk("R9 float", {7'd0, pwr_req_oe}, 8'd0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 5);
      d  = 8'($urandom);
      case (op)
        0: begin wr(1'b0, d); m_ctrl = d; end
        1: begin
          if (!m_pwr) m_ctrl[6] = 1'b1;
          m_pwr = ~m_pwr; main_pwr = m_pwr; step(1);
        end
        2: begin wake_evt = 1'b1; step(1); wake_evt = 1'b0; m_wf = 1; end
        3: begin kick_n = 1'b0; step(3); kick_n = 1'b1; m_kf = 1; end
        default: begin
          wr(1'b1, d);
          if (d[1]) m_wf = 0;
          if (d[0]) m_kf = 0;
        end
      endcase
      step(6);
      check_all("rand R6 R8");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule